// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block merges eight interrupt request lines into a single interrupt output for an 8-bit processor. Each request line can be edge or level sensitive, and any line can be masked. A fixed priority decides which request is served, with line 0 the highest. A request is passed to the processor only when it outranks every level that is already being serviced, so service routines can nest.

When the processor acknowledges, the block answers with a three-byte subroutine call. The first byte is the call opcode 0xCD. The second and third bytes are the low and high bytes of the service address for the chosen line. The host programs the block through a one-address-bit register port. Initialization words set the address base, the address interval, the trigger mode and the end-of-service mode. Operation words then write the mask, end a service, and choose which status register a read returns.

A role input selects master or slave. Only a master drives the opcode byte. All ports are synchronous to `clk`. Each `ack` strobe is one clock wide and counts as one acknowledge pulse, and the bus byte is valid in the cycle of that pulse.

Top module: `vpic_top`

## Requirements
- R1: After reset the request and in-service registers are zero, every mask bit is one, and `intr` stays low until the initialization sequence has completed.
- R2: A write with `a0`=0 and bit 4 set begins initialization and clears the mask. In that word, bit 3 selects level trigger, bit 2 selects a 4-byte interval (8 bytes otherwise), bits 7:5 give the upper bits of the low address byte, and bit 0 announces a mode word. The next `a0`=1 write is the address high byte. If a mode word was announced, one further `a0`=1 write follows, in which bit 1 enables automatic end of service.
- R3: In edge mode a rising edge on a line sets its request bit, and the bit is held until that line is acknowledged. In level mode the request bit follows the line.
- R4: After initialization, an `a0`=1 write loads the mask and an `a0`=1 read returns it. A masked line is still recorded in the request register, but it never raises `intr`.
- R5: Priority is fixed with line 0 the highest. The block serves the lowest-numbered unmasked pending line.
- R6: On acknowledge pulses 1, 2 and 3 a master drives 0xCD, then the low address byte, then the high address byte. The low byte is {bits7:5, line, 00} for a 4-byte interval and {bits7:6, line, 000} for an 8-byte interval.
- R7: With `master` low, the first pulse drives nothing (`dout_en` low, `dout` zero). Pulses 2 and 3 behave as for a master.
- R8: The first pulse moves the served line from the request register into the in-service register.
- R9: A write with `a0`=0, bits 4:3 = 00 and bits 7:5 = 001 clears the highest-priority in-service bit. The code 011 clears the in-service bit numbered by bits 2:0.
- R10: With automatic end of service enabled, the in-service bit clears at the end of the third pulse.
- R11: A write with `a0`=0, bit 4 = 0 and bit 3 = 1 whose bit 1 is set makes `a0`=0 reads return the in-service register (bit 0 = 1) or the request register (bit 0 = 0). Reset selects the request register.
- R12: While a line is in service, a pending line of higher priority raises `intr`; a pending line of equal or lower priority does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 8 | Interrupt request lines, line 0 highest |
| intr | output | 1 | Interrupt request to the processor |
| cs | input | 1 | Register port select |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or acknowledge byte, zero when not driven |
| dout_en | output | 1 | High while `dout` carries a byte |
| ack | input | 1 | Acknowledge pulse strobe, one cycle per pulse |
| master | input | 1 | Role select: 1 master, 0 slave |

## Verification
On every cycle, the assertions check four things. `intr` is silent before initialization and never points at a masked-only request. The acknowledge sequencer steps opcode, low, high and back. A taken line lands in service, and both end-of-service paths remove exactly the expected bit. The bench scenarios are needed for the rest: the actual byte values, including the address concatenation for both intervals, and slave-role suppression of the opcode. They also cover ordering when requests nest, where a lower line must stay hidden until earlier services end, and the difference between edge latching and level following.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int NUM_IR = 8;
    localparam int IDX_W  = $clog2(NUM_IR);
    localparam int DW     = 8;
    localparam logic [DW-1:0] CALL_OP = 8'hCD;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [NUM_IR-1:0] irvec_t;
    typedef logic [DW-1:0]     byte_t;

    typedef enum logic [1:0] {
        INIT_OFF,
        INIT_HI,
        INIT_MODE,
        INIT_RUN
    } init_e;

    typedef enum logic [1:0] {
        SEQ_OPC,
        SEQ_LO,
        SEQ_HI
    } seq_e;

    typedef struct packed {
        logic       level;
        logic       step4;
        logic       aeoi;
        logic [2:0] lo_bits;
        byte_t      hi_byte;
    } cfg_t;

    // lowest-numbered set bit, i.e. highest priority
    function automatic idx_t first_set(irvec_t v);
        idx_t r;
        r = '0;
        for (int i = NUM_IR - 1; i >= 0; i--) begin
            if (v[i]) r = idx_t'(i);
        end
        return r;
    endfunction

    function automatic byte_t addr_lo(logic step4, logic [2:0] hi3, idx_t n);
        if (step4) return {hi3, n, 2'b00};
        return {hi3[2:1], n, 3'b000};
    endfunction

endpackage

// File: rtl/vpic_cmd.sv
module vpic_cmd
    import vpic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs,
    input  logic  wr,
    input  logic  a0,
    input  byte_t din,
    output cfg_t  cfg,
    output irvec_t imr,
    output logic  running,
    output logic  rd_isr,
    output logic  eoi_any,
    output logic  eoi_spec,
    output idx_t  eoi_idx
);

    init_e st;
    logic  need_mode;
    logic  wr_ctl;
    logic  wr_op;

    assign wr_ctl  = cs && wr && !a0;
    assign wr_op   = wr_ctl && !din[4] && !din[3] && (st == INIT_RUN);
    assign eoi_any  = wr_op && (din[7:5] == 3'b001);
    assign eoi_spec = wr_op && (din[7:5] == 3'b011);
    assign eoi_idx  = din[IDX_W-1:0];
    assign running  = (st == INIT_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= INIT_OFF;
            cfg       <= '0;
            imr       <= '1;
            rd_isr    <= 1'b0;
            need_mode <= 1'b0;
        end else if (cs && wr) begin
            if (!a0 && din[4]) begin
                st          <= INIT_HI;
                imr         <= '0;
                cfg.level   <= din[3];
                cfg.step4   <= din[2];
                cfg.lo_bits <= din[7:5];
                cfg.aeoi    <= 1'b0;
                need_mode   <= din[0];
                rd_isr      <= 1'b0;
            end else if (a0) begin
                case (st)
                    INIT_HI: begin
                        cfg.hi_byte <= din;
                        st <= need_mode ? INIT_MODE : INIT_RUN;
                    end
                    INIT_MODE: begin
                        cfg.aeoi <= din[1];
                        st <= INIT_RUN;
                    end
                    INIT_RUN: imr <= din;
                    default: ;
                endcase
            end else if (st == INIT_RUN && din[3] && din[1]) begin
                rd_isr <= din[0];
            end
        end
    end

    // R1: once running, only a fresh initialization word can leave that state
    a_r1_run_holds: assert property (@(posedge clk) disable iff (rst)
        running && !(cs && wr && !a0 && din[4]) |=> running);

endmodule

// File: rtl/vpic_req.sv
module vpic_req
    import vpic_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  irvec_t irq,
    input  logic   level,
    input  logic   take,
    input  idx_t   take_idx,
    input  logic   eoi_any,
    input  logic   eoi_spec,
    input  idx_t   eoi_idx,
    input  logic   auto_clr,
    input  idx_t   auto_idx,
    output irvec_t irr,
    output irvec_t isr
);

    irvec_t irq_q;
    irvec_t irr_n;
    irvec_t isr_n;
    irvec_t take_mask;

    always_comb begin
        take_mask = '0;
        if (take) take_mask[take_idx] = 1'b1;
        if (level) irr_n = irq;
        else       irr_n = (irr & ~take_mask) | (irq & ~irq_q);

        isr_n = isr | take_mask;
        if (eoi_any && isr != '0) isr_n[first_set(isr)] = 1'b0;
        if (eoi_spec) isr_n[eoi_idx] = 1'b0;
        if (auto_clr) isr_n[auto_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            irr   <= '0;
            isr   <= '0;
        end else begin
            irq_q <= irq;
            irr   <= irr_n;
            isr   <= isr_n;
        end
    end

    // R8: a taken line is in service on the next cycle
    a_r8_take_sets_isr: assert property (@(posedge clk) disable iff (rst)
        take && !eoi_any && !eoi_spec |=> isr[$past(take_idx)]);

    // R9: a non-specific end of service removes exactly one bit
    a_r9_eoi_one_bit: assert property (@(posedge clk) disable iff (rst)
        eoi_any && isr != '0 && !take && !eoi_spec && !auto_clr
        |=> $countones(isr) == $countones($past(isr)) - 1);

    // R10: automatic end of service clears the served bit
    a_r10_auto_clears: assert property (@(posedge clk) disable iff (rst)
        auto_clr && !take |=> !isr[$past(auto_idx)]);

endmodule

// File: rtl/vpic_prio.sv
module vpic_prio
    import vpic_pkg::*;
(
    input  irvec_t irr,
    input  irvec_t imr,
    input  irvec_t isr,
    input  logic   running,
    output logic   pend_any,
    output idx_t   best_idx,
    output logic   intr
);

    irvec_t pend;
    idx_t   svc_idx;
    logic   outranks;

    always_comb begin
        pend     = irr & ~imr;
        pend_any = (pend != '0);
        best_idx = first_set(pend);
        svc_idx  = first_set(isr);
        outranks = (isr == '0) || (best_idx < svc_idx);
        intr     = running && pend_any && outranks;
    end

endmodule

// File: rtl/vpic_ack.sv
module vpic_ack
    import vpic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ack,
    input  logic       master,
    input  logic       pend_any,
    input  idx_t       best_idx,
    input  logic       step4,
    input  logic       aeoi,
    input  logic [2:0] lo_bits,
    input  byte_t      hi_byte,
    output logic       take,
    output idx_t       take_idx,
    output logic       auto_clr,
    output idx_t       auto_idx,
    output byte_t      bus_byte,
    output logic       bus_en
);

    seq_e st;
    idx_t cur;
    logic cur_valid;

    assign take     = ack && (st == SEQ_OPC) && pend_any;
    assign take_idx = best_idx;
    assign auto_clr = ack && (st == SEQ_HI) && aeoi && cur_valid;
    assign auto_idx = cur;

    always_comb begin
        bus_byte = '0;
        bus_en   = 1'b0;
        case (st)
            SEQ_OPC: begin
                bus_en   = ack && master;
                bus_byte = CALL_OP;
            end
            SEQ_LO: begin
                bus_en   = ack;
                bus_byte = addr_lo(step4, lo_bits, cur);
            end
            SEQ_HI: begin
                bus_en   = ack;
                bus_byte = hi_byte;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SEQ_OPC;
            cur       <= '0;
            cur_valid <= 1'b0;
        end else if (ack) begin
            case (st)
                SEQ_OPC: begin
                    cur       <= pend_any ? best_idx : '1;
                    cur_valid <= pend_any;
                    st        <= SEQ_LO;
                end
                SEQ_LO:  st <= SEQ_HI;
                default: st <= SEQ_OPC;
            endcase
        end
    end

    // R6: pulse order is opcode, low byte, high byte, then back
    a_r6_opc_to_lo: assert property (@(posedge clk) disable iff (rst)
        ack && st == SEQ_OPC |=> st == SEQ_LO);
    a_r6_hi_to_opc: assert property (@(posedge clk) disable iff (rst)
        ack && st == SEQ_HI |=> st == SEQ_OPC);
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !ack |=> $stable(st));

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] irq,
    output logic       intr,
    input  logic       cs,
    input  logic       wr,
    input  logic       rd,
    input  logic       a0,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       dout_en,
    input  logic       ack,
    input  logic       master
);

    cfg_t   cfg;
    irvec_t imr, irr, isr;
    logic   running, rd_isr;
    logic   eoi_any, eoi_spec;
    idx_t   eoi_idx;
    logic   pend_any;
    idx_t   best_idx;
    logic   take, auto_clr;
    idx_t   take_idx, auto_idx;
    byte_t  bus_byte;
    logic   bus_en;

    vpic_cmd u_cmd (
        .clk(clk), .rst(rst), .cs(cs), .wr(wr), .a0(a0), .din(din),
        .cfg(cfg), .imr(imr), .running(running), .rd_isr(rd_isr),
        .eoi_any(eoi_any), .eoi_spec(eoi_spec), .eoi_idx(eoi_idx)
    );

    vpic_req u_req (
        .clk(clk), .rst(rst), .irq(irq), .level(cfg.level),
        .take(take), .take_idx(take_idx),
        .eoi_any(eoi_any), .eoi_spec(eoi_spec), .eoi_idx(eoi_idx),
        .auto_clr(auto_clr), .auto_idx(auto_idx),
        .irr(irr), .isr(isr)
    );

    vpic_prio u_prio (
        .irr(irr), .imr(imr), .isr(isr), .running(running),
        .pend_any(pend_any), .best_idx(best_idx), .intr(intr)
    );

    vpic_ack u_ack (
        .clk(clk), .rst(rst), .ack(ack), .master(master),
        .pend_any(pend_any), .best_idx(best_idx),
        .step4(cfg.step4), .aeoi(cfg.aeoi), .lo_bits(cfg.lo_bits),
        .hi_byte(cfg.hi_byte),
        .take(take), .take_idx(take_idx),
        .auto_clr(auto_clr), .auto_idx(auto_idx),
        .bus_byte(bus_byte), .bus_en(bus_en)
    );

    always_comb begin
        dout    = '0;
        dout_en = 1'b0;
        if (bus_en) begin
            dout    = bus_byte;
            dout_en = 1'b1;
        end else if (cs && rd) begin
            dout    = a0 ? imr : (rd_isr ? isr : irr);
            dout_en = 1'b1;
        end
    end

    // R1: nothing reaches the processor before initialization completes
    a_r1_silent_uninit: assert property (@(posedge clk) disable iff (rst)
        !running |-> !intr);

    // R4: an asserted interrupt always has an unmasked pending request
    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        intr |-> (irr & ~imr) != '0);

endmodule

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;

    localparam int CLK_P = 10;
    localparam int OP_WR  = 1;
    localparam int OP_RD  = 2;
    localparam int OP_IRQ = 3;
    localparam int OP_ACK = 4;
    localparam int OP_INT = 5;
    localparam int NVEC   = 48;

    // {tag, op, a0 / expected enable, data, expected}
    // R2 init 0xB5: base bits 101, 4-byte interval, mode word; high 0x20
    // R3 edge latch, R4 mask, R5 priority, R6 bytes, R8 move to service,
    // R9 end of service, R11 status select, R12 nesting
    localparam logic [31:0] VEC [NVEC] = '{
        32'h02_1_0_B5_00, 32'h02_1_1_20_00, 32'h01_5_0_00_00, 32'h02_1_1_00_00,
        32'h02_2_1_00_00, 32'h04_1_1_80_00, 32'h04_2_1_00_80, 32'h03_3_0_08_00,
        32'h03_5_0_00_01, 32'h0B_1_0_0A_00, 32'h0B_2_0_00_08, 32'h06_4_1_00_CD,
        32'h06_4_1_00_AC, 32'h06_4_1_00_20, 32'h08_5_0_00_00, 32'h0B_1_0_0B_00,
        32'h08_2_0_00_08, 32'h0C_3_0_28_00, 32'h0C_5_0_00_00, 32'h0C_3_0_2A_00,
        32'h0C_5_0_00_01, 32'h06_4_1_00_CD, 32'h05_4_1_00_A4, 32'h06_4_1_00_20,
        32'h0C_2_0_00_0A, 32'h05_5_0_00_00, 32'h09_1_0_20_00, 32'h09_2_0_00_08,
        32'h09_1_0_20_00, 32'h09_2_0_00_00, 32'h05_5_0_00_01, 32'h06_4_1_00_CD,
        32'h06_4_1_00_B4, 32'h06_4_1_00_20, 32'h09_1_0_65_00, 32'h09_2_0_00_00,
        32'h03_3_0_00_00, 32'h04_3_0_80_00, 32'h04_5_0_00_00, 32'h0B_1_0_0A_00,
        32'h04_2_0_00_80, 32'h04_1_1_00_00, 32'h04_5_0_00_01, 32'h06_4_1_00_CD,
        32'h06_4_1_00_BC, 32'h06_4_1_00_20, 32'h09_1_0_20_00, 32'h08_2_0_00_00
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq = '0;
    logic       intr;
    logic       cs = 1'b0, wr = 1'b0, rd = 1'b0, a0 = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_en;
    logic       ack = 1'b0;
    logic       master = 1'b1;

    int nchk  = 0;
    int nfail = 0;

    always #(CLK_P/2) clk = ~clk;

    vpic_top dut_i (
        .clk(clk), .rst(rst), .irq(irq), .intr(intr),
        .cs(cs), .wr(wr), .rd(rd), .a0(a0), .din(din),
        .dout(dout), .dout_en(dout_en), .ack(ack), .master(master)
    );

    task automatic check(input int tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL R%0d: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input int op, input logic a, input logic [7:0] d,
                        input logic [7:0] e, input int tag);
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; rd = 1'b0; ack = 1'b0;
        case (op)
            OP_WR:  begin cs = 1'b1; wr = 1'b1; a0 = a; din = d; end
            OP_RD:  begin cs = 1'b1; rd = 1'b1; a0 = a; end
            OP_IRQ: irq = d;
            OP_ACK: ack = 1'b1;
            default: ;
        endcase
        #(CLK_P/4);
        case (op)
            OP_RD:  check(tag, dout, e);
            OP_ACK: begin
                check(tag, dout, e);
                check(tag, {7'b0, dout_en}, {7'b0, a});
            end
            OP_INT: check(tag, {7'b0, intr}, e);
            default: ;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cs = 1'b0; wr = 1'b0; rd = 1'b0; ack = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state: mask all ones, request register clear, no interrupt
        step(OP_RD, 1'b1, 8'h00, 8'hFF, 1);
        step(OP_RD, 1'b0, 8'h00, 8'h00, 1);
        step(OP_INT, 1'b0, 8'h00, 8'h00, 1);

        for (int i = 0; i < NVEC; i++) begin
            step(int'(VEC[i][23:20]), VEC[i][16], VEC[i][15:8],
                 VEC[i][7:0], int'(VEC[i][31:24]));
        end

        // R7 / R10 / R3: slave role, level trigger, 8-byte interval, auto end
        do_reset();
        master = 1'b0;
        step(OP_IRQ, 1'b0, 8'h04, 8'h00, 3);
        step(OP_WR, 1'b0, 8'hD9, 8'h00, 2);
        step(OP_WR, 1'b1, 8'h40, 8'h00, 2);
        step(OP_INT, 1'b0, 8'h00, 8'h00, 1);   // R1: mode word still owed
        step(OP_WR, 1'b1, 8'h02, 8'h00, 2);
        step(OP_INT, 1'b0, 8'h00, 8'h01, 3);   // R3: level request seen
        step(OP_ACK, 1'b0, 8'h00, 8'h00, 7);   // R7: slave drives no opcode
        step(OP_ACK, 1'b1, 8'h00, 8'hD0, 6);   // R6: {11,010,000}
        step(OP_ACK, 1'b1, 8'h00, 8'h40, 6);
        step(OP_WR, 1'b0, 8'h0B, 8'h00, 11);
        step(OP_RD, 1'b0, 8'h00, 8'h00, 10);   // R10: service cleared itself
        step(OP_INT, 1'b0, 8'h00, 8'h01, 10);  // R10: level still high
        step(OP_IRQ, 1'b0, 8'h00, 8'h00, 3);
        step(OP_WR, 1'b0, 8'h0A, 8'h00, 11);
        step(OP_RD, 1'b0, 8'h00, 8'h00, 3);    // R3: level request follows line
        step(OP_INT, 1'b0, 8'h00, 8'h00, 3);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule